// File: doc/BRIEF.md
# Show-Ahead Byte Queue with Sticky Error Flags

This block is a single-clock first-in first-out store for bytes. Its depth is a power of two set by a log2 parameter. The oldest stored byte is always driven on the read data output, before any read strobe arrives. A consumer looks at the byte and pulses its ready input to move on to the next one. The block also reports how many bytes it holds. Two error conditions latch and stay set until they are cleared: a write that arrives with no room, and a read that arrives with nothing to read.

Both data sides use valid/ready naming. On the write side, `wr_ready` is high while the store has room. A producer that drives `wr_valid` while `wr_ready` is low loses that byte and sets the overflow flag. The one exception is a read in the same cycle, which frees a slot, so the byte is accepted. On the read side, `rd_valid` is high while at least one byte is held, and `rd_data` shows the head byte. A cycle with `rd_ready` high and `rd_valid` high removes the head byte. A cycle with `rd_ready` high and `rd_valid` low sets the underflow flag. Two clear inputs are provided. `flush` discards all contents and clears both flags. `err_clr` clears only the flags and leaves the contents and count untouched.

Top module: `byte_lookahead_fifo`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block afterwards holds no bytes: `fill_count` is 0, `rd_valid` is 0, `wr_ready` is 1, and both flags are 0.
- R2: While `rd_valid` is high, `rd_data` shows the oldest byte not yet removed, with no strobe needed. Bytes come out in the order they were accepted.
- R3: `rd_valid` is high exactly when `fill_count` is non-zero. `wr_ready` is high exactly when `fill_count` is below 2^ADDR_W.
- R4: `fill_count` rises by one on an accepted write alone, falls by one on an accepted read alone, and is unchanged when both happen in the same cycle. It never exceeds 2^ADDR_W.
- R5: A write with the store full and no read in the same cycle is dropped. The count and head byte are unchanged. `overflow` goes to 1 and stays at 1 until it is cleared.
- R6: A read strobe with the store empty leaves the count at 0. `underflow` goes to 1 and stays at 1 until it is cleared.
- R7: `err_clr` sets both flags to 0 after the edge, and keeps the stored bytes, the head byte and the count.
- R8: A write and a read in the same cycle with the store full remove the head byte and store the new byte at the tail. The count stays at 2^ADDR_W and `overflow` does not rise.
- R9: While the store is empty, `rd_data` reads as 0.
- R10: `flush` empties the store and clears both flags. A write or read strobe in the same cycle as `flush` has no effect.
- R11: A new overflow or underflow event in the same cycle as `err_clr` still leaves its flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Discard all contents and clear both flags |
| err_clr | input | 1 | Clear both flags, keep contents |
| wr_valid | input | 1 | Write request for `wr_data` |
| wr_data | input | DATA_W | Byte to store |
| wr_ready | output | 1 | Room for at least one more byte |
| rd_valid | output | 1 | At least one byte stored |
| rd_data | output | DATA_W | Head byte, zero when empty |
| rd_ready | input | 1 | Remove the head byte |
| fill_count | output | ADDR_W+1 | Number of bytes stored |
| overflow | output | 1 | Sticky: a write was dropped |
| underflow | output | 1 | Sticky: a read hit an empty store |

## Verification
A wrong pointer shows on `rd_data` right after the edge that corrupts it. A head pointer that advanced wrongly shows the next byte early. A tail pointer that failed to advance shows as an earlier byte being overwritten when that byte reaches the head. A count that drifts from the pointers shows within one edge as a wrong `fill_count`, and then as `rd_valid` or `wr_ready` flipping at the wrong fill level. A flag with the wrong set or clear priority shows one edge after an event coincides with a clear or with a full-state swap, so the stimulus forces these overlaps on purpose.

// File: rtl/bytefifo_pkg.sv
`timescale 1ns/1ps
package bytefifo_pkg;
  // Sticky error state kept by the flag register.
  typedef struct packed {
    logic ovf;
    logic unf;
  } err_flags_t;

  // Number of slots for a given address width.
  function automatic int unsigned slots_for(int unsigned aw);
    return 32'd1 << aw;
  endfunction
endpackage

// File: rtl/bytefifo_ptr_ctrl.sv
`timescale 1ns/1ps
module bytefifo_ptr_ctrl #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_valid,
  input  logic              rd_ready,
  output logic              push,
  output logic              pop,
  output logic              ovf_evt,
  output logic              unf_evt,
  output logic              full,
  output logic              empty,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic [ADDR_W:0]   count
);
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] DEPTH = CNT_W'(bytefifo_pkg::slots_for(ADDR_W));
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  assign empty = (count == '0);
  assign full  = (count == DEPTH);

  // A read is taken only when something is stored; a write is taken when
  // there is room or when the same-cycle read frees a slot.
  assign pop     = rd_ready && !empty && !flush;
  assign push    = wr_valid && (!full || pop) && !flush;
  assign ovf_evt = wr_valid && full && !pop && !flush;
  assign unf_evt = rd_ready && empty && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + ONE;
        2'b01:   count <= count - ONE;
        default: count <= count;
      endcase
    end
  end

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(flush)) |->
      (count == $past(count) || count == $past(count) + ONE || count == $past(count) - ONE));

  // R8
  full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_valid && rd_ready && !flush) |=> (count == DEPTH));
endmodule

// File: rtl/bytefifo_store.sv
`timescale 1ns/1ps
module bytefifo_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              push,
  input  logic              empty,
  input  logic [ADDR_W-1:0] wr_ptr,
  input  logic [ADDR_W-1:0] rd_ptr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] slot [DEPTH];

  always_ff @(posedge clk) begin
    if (push) slot[wr_ptr] <= wr_data;
  end

  // Show-ahead: the head slot is driven combinationally, masked to zero when
  // nothing is stored so stale slot contents never leak out.
  assign rd_data = empty ? '0 : slot[rd_ptr];
endmodule

// File: rtl/bytefifo_sticky_flags.sv
`timescale 1ns/1ps
module bytefifo_sticky_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic err_clr,
  input  logic ovf_evt,
  input  logic unf_evt,
  output logic overflow,
  output logic underflow
);
  import bytefifo_pkg::*;

  err_flags_t flags_q;

  // Set beats clear so an event in the clearing cycle is never lost;
  // flush and reset win over everything (events are already gated by flush).
  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      flags_q <= '0;
    end else begin
      flags_q.ovf <= (flags_q.ovf && !err_clr) || ovf_evt;
      flags_q.unf <= (flags_q.unf && !err_clr) || unf_evt;
    end
  end

  assign overflow  = flags_q.ovf;
  assign underflow = flags_q.unf;

  // R5
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !err_clr && !flush) |=> overflow);

  // R6
  unf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> underflow);

  // R7
  err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !ovf_evt && !unf_evt) |=> (!overflow && !underflow));
endmodule

// File: rtl/byte_lookahead_fifo.sv
`timescale 1ns/1ps
module byte_lookahead_fifo #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              err_clr,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rd_ready,
  output logic [ADDR_W:0]   fill_count,
  output logic              overflow,
  output logic              underflow
);
  logic              push, pop, ovf_evt, unf_evt, full, empty;
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;

  bytefifo_ptr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .wr_valid (wr_valid),
    .rd_ready (rd_ready),
    .push     (push),
    .pop      (pop),
    .ovf_evt  (ovf_evt),
    .unf_evt  (unf_evt),
    .full     (full),
    .empty    (empty),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .count    (fill_count)
  );

  bytefifo_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .push    (push),
    .empty   (empty),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  bytefifo_sticky_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .err_clr   (err_clr),
    .ovf_evt   (ovf_evt),
    .unf_evt   (unf_evt),
    .overflow  (overflow),
    .underflow (underflow)
  );

  assign rd_valid = !empty;
  assign wr_ready = !full;

  // R2
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !flush) |=> $stable(rd_data));

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!rd_valid && !overflow && !underflow));
endmodule

// File: tb/byte_lookahead_fifo_bench.sv
`timescale 1ns/1ps
module byte_lookahead_fifo_bench;
  localparam int AW = 2;
  localparam int DW = 8;

  typedef struct packed {
    logic       wv;
    logic [7:0] wd;
    logic       rr;
    logic       ec;
    logic       fl;
    logic [2:0] cnt;
    logic       ovf;
    logic       unf;
    logic       rdv;
    logic       wrdy;
    logic [7:0] rdd;
    logic [3:0] req;
  } vec_t;

  // inputs: wv wd rr ec fl | expected after edge: cnt ovf unf rdv wrdy rdd | requirement
  localparam vec_t VECS [23] = '{
    '{1'b0,8'h00,1'b0,1'b0,1'b0, 3'd0,1'b0,1'b0,1'b0,1'b1,8'h00, 4'd9},  // R9 idle empty
    '{1'b0,8'h00,1'b1,1'b0,1'b0, 3'd0,1'b0,1'b1,1'b0,1'b1,8'h00, 4'd6},  // R6 read empty
    '{1'b0,8'h00,1'b0,1'b1,1'b0, 3'd0,1'b0,1'b0,1'b0,1'b1,8'h00, 4'd7},  // R7 clear
    '{1'b1,8'hA1,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b0,1'b1,1'b1,8'hA1, 4'd2},  // R2 first byte visible
    '{1'b1,8'hB2,1'b0,1'b0,1'b0, 3'd2,1'b0,1'b0,1'b1,1'b1,8'hA1, 4'd2},  // R2 head kept
    '{1'b1,8'hC3,1'b0,1'b0,1'b0, 3'd3,1'b0,1'b0,1'b1,1'b1,8'hA1, 4'd4},  // R4 count up
    '{1'b1,8'hD4,1'b0,1'b0,1'b0, 3'd4,1'b0,1'b0,1'b1,1'b0,8'hA1, 4'd3},  // R3 full, not ready
    '{1'b1,8'hE5,1'b0,1'b0,1'b0, 3'd4,1'b1,1'b0,1'b1,1'b0,8'hA1, 4'd5},  // R5 dropped
    '{1'b0,8'h00,1'b0,1'b0,1'b0, 3'd4,1'b1,1'b0,1'b1,1'b0,8'hA1, 4'd5},  // R5 sticky
    '{1'b1,8'h66,1'b1,1'b0,1'b0, 3'd4,1'b1,1'b0,1'b1,1'b0,8'hB2, 4'd8},  // R8 full swap
    '{1'b0,8'h00,1'b0,1'b1,1'b0, 3'd4,1'b0,1'b0,1'b1,1'b0,8'hB2, 4'd7},  // R7 data kept
    '{1'b0,8'h00,1'b1,1'b0,1'b0, 3'd3,1'b0,1'b0,1'b1,1'b1,8'hC3, 4'd2},  // R2 order
    '{1'b0,8'h00,1'b1,1'b0,1'b0, 3'd2,1'b0,1'b0,1'b1,1'b1,8'hD4, 4'd2},  // R2 order
    '{1'b0,8'h00,1'b1,1'b0,1'b0, 3'd1,1'b0,1'b0,1'b1,1'b1,8'h66, 4'd8},  // R8 swapped byte stored
    '{1'b1,8'h77,1'b1,1'b0,1'b0, 3'd1,1'b0,1'b0,1'b1,1'b1,8'h77, 4'd4},  // R4 both, count held
    '{1'b0,8'h00,1'b1,1'b0,1'b0, 3'd0,1'b0,1'b0,1'b0,1'b1,8'h00, 4'd9},  // R9 drained to zero
    '{1'b0,8'h00,1'b1,1'b1,1'b0, 3'd0,1'b0,1'b1,1'b0,1'b1,8'h00, 4'd11}, // R11 event beats clear
    '{1'b1,8'h88,1'b0,1'b0,1'b1, 3'd0,1'b0,1'b0,1'b0,1'b1,8'h00, 4'd10}, // R10 flush wins
    '{1'b1,8'h99,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b0,1'b1,1'b1,8'h99, 4'd4},  // R4 write
    '{1'b0,8'h00,1'b1,1'b0,1'b1, 3'd0,1'b0,1'b0,1'b0,1'b1,8'h00, 4'd10}, // R10 flush with read
    '{1'b1,8'hAA,1'b1,1'b0,1'b0, 3'd1,1'b0,1'b1,1'b1,1'b1,8'hAA, 4'd6},  // R6 write plus empty read
    '{1'b0,8'h00,1'b0,1'b1,1'b0, 3'd1,1'b0,1'b0,1'b1,1'b1,8'hAA, 4'd7},  // R7 byte kept
    '{1'b0,8'h00,1'b1,1'b0,1'b0, 3'd0,1'b0,1'b0,1'b0,1'b1,8'h00, 4'd3}   // R3 empty again
  };

  logic          clk = 1'b0;
  logic          rst_n, flush, err_clr, wr_valid, rd_ready;
  logic [DW-1:0] wr_data;
  logic          wr_ready, rd_valid, overflow, underflow;
  logic [DW-1:0] rd_data;
  logic [AW:0]   fill_count;
  int            checks = 0;
  int            fails  = 0;

  always #2.5 clk = ~clk;

  byte_lookahead_fifo #(.ADDR_W(AW), .DATA_W(DW)) u_byte_lookahead_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .err_clr    (err_clr),
    .wr_valid   (wr_valid),
    .wr_data    (wr_data),
    .wr_ready   (wr_ready),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .rd_ready   (rd_ready),
    .fill_count (fill_count),
    .overflow   (overflow),
    .underflow  (underflow)
  );

  function automatic logic [14:0] observed();
    return {fill_count, overflow, underflow, rd_valid, wr_ready, rd_data};
  endfunction

  task automatic check(string tag, logic [14:0] exp);
    checks++;
    if (observed() !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cnt,ovf,unf,rdv,wrdy,data)", tag, observed(), exp);
    end
  endtask

  task automatic apply(logic wv, logic [7:0] wd, logic rr, logic ec, logic fl);
    @(negedge clk);
    wr_valid = wv; wr_data = wd; rd_ready = rr; err_clr = ec; flush = fl;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flush = 1'b0; err_clr = 1'b0; wr_valid = 1'b0; rd_ready = 1'b0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset state", {3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00});
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 23; i++) begin
      apply(VECS[i].wv, VECS[i].wd, VECS[i].rr, VECS[i].ec, VECS[i].fl);
      check($sformatf("R%0d row %0d", VECS[i].req, i),
            {VECS[i].cnt, VECS[i].ovf, VECS[i].unf, VECS[i].rdv, VECS[i].wrdy, VECS[i].rdd});
    end

    // R11: overflow event in the same cycle as err_clr keeps the flag
    for (int k = 0; k < 4; k++) apply(1'b1, 8'h10 + 8'(k), 1'b0, 1'b0, 1'b0);
    check("R4 filled to depth", {3'd4, 1'b0, 1'b0, 1'b1, 1'b0, 8'h10});
    apply(1'b1, 8'h5A, 1'b0, 1'b1, 1'b0);
    check("R11 overflow beats clear", {3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 8'h10});
    apply(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    check("R5 dropped byte absent", {3'd3, 1'b1, 1'b0, 1'b1, 1'b1, 8'h11});

    // R1: reset mid-stream empties and clears
    @(negedge clk);
    rst_n = 1'b0; rd_ready = 1'b0;
    @(posedge clk);
    #1;
    check("R1 reset while holding data", {3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00});
    @(negedge clk);
    rst_n = 1'b1;
    apply(1'b1, 8'hC7, 1'b0, 1'b0, 1'b0);
    check("R2 fresh byte after reset", {3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hC7});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule